// File: doc/BRIEF.md
# Genlocked Video Frame and Line Sync Generator

This block sets the raster timing of a parallel video port running on the pixel clock. Its output is a frame-valid strobe, a line-valid strobe and a 14-bit data bus. Each active line keeps line-valid high for a fixed number of pixel clocks, and each frame holds a fixed number of active lines. Frame-valid opens a programmable number of clocks ahead of the first line and closes a programmable number of clocks after the last line. Horizontal blanking between lines is programmable as well.

The start of a frame comes from one of two sources. In follower mode it is a rising edge on an asynchronous genlock input, which passes through a two-flop synchroniser before edge detection. In leader mode it is an internal rate counter, and the block drives a short genlock pulse out at each frame start with the pad enable raised. While no frame is due, the block keeps emitting filler line pulses with frame-valid low, so the downstream row timing never stops. An edge that arrives inside a frame is remembered and starts the next frame as soon as the current one has finished. Several such edges count as one.

Pixels come in on a valid/ready stream. The raster cannot be stalled. `pix_ready` is a timing strobe that asks for one word in each cycle before an active pixel slot. A source that has no word at that moment (`pix_valid` low) gets a zero pixel in that slot. It has no way to apply back-pressure. A width select picks either the full 14 bits or an 8-bit value packed into the upper byte lanes.

Top module: `gl_frame_sync`

## Requirements
- R1: Every line-valid pulse lasts exactly ACT_PIX consecutive clocks, and each frame-valid interval contains exactly ACT_LINES such pulses.
- R2: Frame-valid rises exactly cfg_lead clocks before the first line-valid of its frame. A programmed value of 0 behaves as 1.
- R3: Frame-valid falls exactly cfg_trail clocks after the last line-valid of its frame falls. A value of 0 behaves as 1.
- R4: Inside a frame, line-valid stays low for exactly cfg_hblank clocks between consecutive lines. A value of 0 behaves as 1. Filler lines use the same gap.
- R5: In follower mode (mode_master = 0), no frame starts unless a rising edge has been seen on gl_in. Each edge seen outside a frame starts one frame. The edge is acted on at the end of the first blanking gap after it has passed the synchroniser. The level of gl_in and its high time have no effect.
- R6: While no frame is running, line-valid pulses of ACT_PIX clocks keep coming with frame-valid low, and vid_data is zero during them.
- R7: One or more gl_in rising edges during a frame cause exactly one further frame. That frame begins right after the trail and one blanking gap, with no filler line in between.
- R8: In leader mode (mode_master = 1), a frame request is raised every cfg_period clocks. Requests that arrive while one is pending merge into it. gl_oe is high, and gl_out is high for PULSE_LEN clocks, rising in the same cycle as frame-valid. In follower mode gl_oe and gl_out are low.
- R9: With sel_wide = 1, vid_data equals the accepted pix_data[13:0]. With sel_wide = 0, vid_data[13:6] equals pix_data[7:0] (MSB on bit 13) and vid_data[5:0] is zero.
- R10: pix_ready is high in exactly the cycle before each active pixel slot. The word offered in that cycle appears on vid_data in the next cycle, together with line-valid and frame-valid. If pix_valid is low in that cycle, the slot carries zero.
- R11: During and right after reset, fsync, lsync, vid_data and gl_out are low and the block is in follower idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gl_in | input | 1 | Asynchronous genlock input (follower mode) |
| mode_master | input | 1 | 1 = leader (internal rate), 0 = follower (genlock edge) |
| sel_wide | input | 1 | 1 = 14-bit data, 0 = 8-bit data on the upper lanes |
| cfg_hblank | input | CW | Blanking clocks between lines |
| cfg_lead | input | CW | Clocks from frame-valid rise to first line |
| cfg_trail | input | CW | Clocks from last line end to frame-valid fall |
| cfg_period | input | PERW | Leader-mode frame request period in clocks |
| pix_valid | input | 1 | Source has a word in this cycle |
| pix_data | input | DW | Pixel word |
| pix_ready | output | 1 | Pixel slot strobe; word taken this cycle |
| fsync | output | 1 | Frame-valid, active high |
| lsync | output | 1 | Line-valid, active high |
| vid_data | output | DW | Video data, zero outside active lines |
| gl_out | output | 1 | Genlock pulse out (leader mode) |
| gl_oe | output | 1 | Genlock pad output enable |

## Verification
The hardest case to reach from the ports is a genlock edge that lands inside a running frame, in particular a burst of several edges in one frame that must collapse into a single held request. The bench waits at the ports for frame-valid to rise after a first edge and then fires two short gl_in pulses while the frame is still running. It then expects exactly one more frame and zero filler lines ahead of it. A reduced raster of 8 pixels by 4 lines keeps every line, gap, porch and pixel of every frame cheap enough to check one by one against counts computed from the programmed lengths.

// File: rtl/gfs_pkg.sv
package gfs_pkg;
  typedef enum logic [2:0] {
    ST_FBLK  = 3'd0,  // idle blanking gap, frame may start at its end
    ST_FLINE = 3'd1,  // idle filler line
    ST_LEAD  = 3'd2,  // frame open, before first line
    ST_LINE  = 3'd3,  // active pixels
    ST_HBLK  = 3'd4,  // gap between active lines
    ST_TRAIL = 3'd5   // frame open, after last line
  } rast_st_e;
endpackage

// File: rtl/gfs_edge_sync.sv
module gfs_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], async_in};
  end

  // sh[STAGES-1] is the last synchroniser stage, sh[STAGES] its delayed copy
  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/gfs_rate_gen.sv
module gfs_rate_gen #(
  parameter int PERW = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [PERW-1:0] period,
  output logic            tick
);
  logic [PERW-1:0] cnt;
  logic [PERW-1:0] last;

  assign last = (period == '0) ? '0 : period - 1'b1;
  assign tick = en && (cnt >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!en)  cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/gfs_pix_map.sv
module gfs_pix_map #(
  parameter int DW     = 14,
  parameter int NARROW = 8
) (
  input  logic          sel_wide,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  localparam int PAD = DW - NARROW;

  generate
    if (PAD > 0) begin : g_pad
      always_comb dout = sel_wide ? din : {din[NARROW-1:0], {PAD{1'b0}}};
    end else begin : g_flat
      always_comb dout = din;
    end
  endgenerate
endmodule

// File: rtl/gfs_raster.sv
module gfs_raster
  import gfs_pkg::*;
#(
  parameter int ACT_PIX   = 320,
  parameter int ACT_LINES = 240,
  parameter int CW        = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_hblank,
  input  logic [CW-1:0] cfg_lead,
  input  logic [CW-1:0] cfg_trail,
  input  logic          start_pend,
  output logic          fsync,
  output logic          lsync,
  output logic          take,
  output logic          frame_start
);
  localparam int PIX_W = $clog2(ACT_PIX + 1);
  localparam int CNT_W = (CW > PIX_W) ? CW : PIX_W;
  localparam int LN_W  = $clog2(ACT_LINES + 1);
  localparam logic [CNT_W-1:0] PIX_M1 = CNT_W'(ACT_PIX - 1);
  localparam logic [LN_W-1:0]  LN_END = LN_W'(ACT_LINES - 1);

  rast_st_e         st, nxt;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic [LN_W-1:0]  line, line_nxt;

  function automatic logic [CNT_W-1:0] len_m1(input logic [CW-1:0] v);
    logic [CNT_W-1:0] w;
    w = CNT_W'(v);
    return (w == '0) ? '0 : w - 1'b1;
  endfunction

  always_comb begin
    nxt         = st;
    cnt_nxt     = cnt - 1'b1;
    line_nxt    = line;
    frame_start = 1'b0;
    if (cnt == '0) begin
      case (st)
        ST_FBLK: begin
          if (start_pend) begin
            nxt         = ST_LEAD;
            cnt_nxt     = len_m1(cfg_lead);
            frame_start = 1'b1;
          end else begin
            nxt     = ST_FLINE;
            cnt_nxt = PIX_M1;
          end
        end
        ST_FLINE: begin
          nxt     = ST_FBLK;
          cnt_nxt = len_m1(cfg_hblank);
        end
        ST_LEAD: begin
          nxt      = ST_LINE;
          cnt_nxt  = PIX_M1;
          line_nxt = '0;
        end
        ST_LINE: begin
          if (line == LN_END) begin
            nxt     = ST_TRAIL;
            cnt_nxt = len_m1(cfg_trail);
          end else begin
            nxt     = ST_HBLK;
            cnt_nxt = len_m1(cfg_hblank);
          end
        end
        ST_HBLK: begin
          nxt      = ST_LINE;
          cnt_nxt  = PIX_M1;
          line_nxt = line + 1'b1;
        end
        ST_TRAIL: begin
          nxt     = ST_FBLK;
          cnt_nxt = len_m1(cfg_hblank);
        end
        default: begin
          nxt     = ST_FBLK;
          cnt_nxt = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_FBLK;
      cnt  <= '0;
      line <= '0;
    end else begin
      st   <= nxt;
      cnt  <= cnt_nxt;
      line <= line_nxt;
    end
  end

  assign fsync = (st == ST_LEAD) || (st == ST_LINE) || (st == ST_HBLK) || (st == ST_TRAIL);
  assign lsync = (st == ST_LINE) || (st == ST_FLINE);
  assign take  = (nxt == ST_LINE);
endmodule

// File: rtl/gl_frame_sync.sv
module gl_frame_sync #(
  parameter int ACT_PIX   = 320,
  parameter int ACT_LINES = 240,
  parameter int CW        = 12,
  parameter int PERW      = 24,
  parameter int PULSE_LEN = 1,
  parameter int DW        = 14,
  parameter int NARROW    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gl_in,
  input  logic            mode_master,
  input  logic            sel_wide,
  input  logic [CW-1:0]   cfg_hblank,
  input  logic [CW-1:0]   cfg_lead,
  input  logic [CW-1:0]   cfg_trail,
  input  logic [PERW-1:0] cfg_period,
  input  logic            pix_valid,
  input  logic [DW-1:0]   pix_data,
  output logic            pix_ready,
  output logic            fsync,
  output logic            lsync,
  output logic [DW-1:0]   vid_data,
  output logic            gl_out,
  output logic            gl_oe
);
  localparam int PL_W = $clog2(PULSE_LEN + 1);

  logic          gl_rise, rate_tick, start_evt, start_pend;
  logic          take, frame_start;
  logic [DW-1:0] mapped, vid_q;
  logic [PL_W-1:0] pl_cnt;

  gfs_edge_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(gl_in), .rise(gl_rise)
  );

  gfs_rate_gen #(.PERW(PERW)) u_rate (
    .clk(clk), .rst_n(rst_n), .en(mode_master), .period(cfg_period), .tick(rate_tick)
  );

  assign start_evt = mode_master ? rate_tick : gl_rise;

  // a request made while a frame runs is held until the raster can start one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           start_pend <= 1'b0;
    else if (start_evt)   start_pend <= 1'b1;
    else if (frame_start) start_pend <= 1'b0;
  end

  gfs_raster #(.ACT_PIX(ACT_PIX), .ACT_LINES(ACT_LINES), .CW(CW)) u_rast (
    .clk(clk), .rst_n(rst_n),
    .cfg_hblank(cfg_hblank), .cfg_lead(cfg_lead), .cfg_trail(cfg_trail),
    .start_pend(start_pend),
    .fsync(fsync), .lsync(lsync), .take(take), .frame_start(frame_start)
  );

  gfs_pix_map #(.DW(DW), .NARROW(NARROW)) u_map (
    .sel_wide(sel_wide), .din(pix_data), .dout(mapped)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 vid_q <= '0;
    else if (take && pix_valid) vid_q <= mapped;
    else                        vid_q <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          pl_cnt <= '0;
    else if (frame_start && mode_master) pl_cnt <= PL_W'(PULSE_LEN);
    else if (pl_cnt != '0)               pl_cnt <= pl_cnt - 1'b1;
  end

  assign pix_ready = take;
  assign vid_data  = vid_q;
  assign gl_out    = mode_master && (pl_cnt != '0);
  assign gl_oe     = mode_master;
endmodule

// File: rtl/gfs_checker.sv
module gfs_checker #(
  parameter int ACT_PIX = 320,
  parameter int DW      = 14,
  parameter int NARROW  = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sel_wide,
  input logic          pix_ready,
  input logic          fsync,
  input logic          lsync,
  input logic [DW-1:0] vid_data,
  input logic          gl_out
);
  localparam int RW = $clog2(ACT_PIX + 1);
  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run <= '0;
    else if (lsync) run <= run + 1'b1;
    else            run <= '0;
  end

  AST_LINE_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    lsync |-> run < RW'(ACT_PIX)); // R1
  AST_LINE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lsync) |-> run == RW'(ACT_PIX)); // R1
  AST_FRAME_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lsync) && fsync) |-> $past(fsync)); // R2
  AST_FRAME_TRAILS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fsync) |-> (!lsync && !$past(lsync))); // R3
  AST_FILLER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (lsync && !fsync) |-> vid_data == '0); // R6
  AST_GL_WITH_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gl_out) |-> $rose(fsync)); // R8
  AST_NARROW_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (lsync && !$past(sel_wide)) |-> vid_data[DW-NARROW-1:0] == '0); // R9
  AST_READY_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |=> (lsync && fsync)); // R10
endmodule

bind gl_frame_sync gfs_checker #(.ACT_PIX(ACT_PIX), .DW(DW), .NARROW(NARROW)) u_gfs_chk (
  .clk(clk), .rst_n(rst_n), .sel_wide(sel_wide), .pix_ready(pix_ready),
  .fsync(fsync), .lsync(lsync), .vid_data(vid_data), .gl_out(gl_out)
);

// File: tb/gl_frame_sync_test.sv
module gl_frame_sync_test;
  localparam int AP = 8, AL = 4, CW = 8, PERW = 12, PL = 2, DW = 14;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, gl_in = 1'b0, mode_master = 1'b0, sel_wide = 1'b1;
  logic [CW-1:0] cfg_hblank = 3, cfg_lead = 2, cfg_trail = 2;
  logic [PERW-1:0] cfg_period = 60;
  logic pix_valid = 1'b0;
  logic [DW-1:0] pix_data = '0;
  logic pix_ready, fsync, lsync, gl_out, gl_oe;
  logic [DW-1:0] vid_data;

  gl_frame_sync #(.ACT_PIX(AP), .ACT_LINES(AL), .CW(CW), .PERW(PERW),
                  .PULSE_LEN(PL), .DW(DW), .NARROW(8)) uut (
    .clk(clk), .rst_n(rst_n), .gl_in(gl_in), .mode_master(mode_master),
    .sel_wide(sel_wide), .cfg_hblank(cfg_hblank), .cfg_lead(cfg_lead),
    .cfg_trail(cfg_trail), .cfg_period(cfg_period), .pix_valid(pix_valid),
    .pix_data(pix_data), .pix_ready(pix_ready), .fsync(fsync), .lsync(lsync),
    .vid_data(vid_data), .gl_out(gl_out), .gl_oe(gl_oe)
  );

  int n_chk = 0, n_fail = 0;
  int frames = 0, fill_cnt = 0, fill_at_start = 0, run = 0, lines = 0;
  int lead_cnt = 0, gap = 0, glp = 0, glrun = 0, sent = 0, recv = 0;
  bit prev_f = 0, prev_l = 0, prev_g = 0, underrun = 0, done = 0;
  logic [DW-1:0] exp_ring [4];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse(input int hi, input int lo);
    gl_in = 1'b1; cyc(hi);
    gl_in = 1'b0; cyc(lo);
  endtask

  // port monitor and pixel source, both away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (lsync && fsync) begin
          chk(vid_data == exp_ring[recv % 4], "R9/R10 pixel", int'(vid_data), int'(exp_ring[recv % 4]));
          recv++;
        end else if (lsync) chk(vid_data == '0, "R6 filler data", int'(vid_data), 0);
        if (fsync && !prev_f) begin
          frames++; fill_at_start = fill_cnt; fill_cnt = 0; lines = 0; lead_cnt = 0;
        end
        if (fsync && !lsync && lines == 0) lead_cnt++;
        if (lsync && !prev_l) begin
          if (fsync && lines == 0) chk(lead_cnt == eff(int'(cfg_lead)), "R2 lead", lead_cnt, eff(int'(cfg_lead)));
          else if (fsync) chk(gap == eff(int'(cfg_hblank)), "R4 hblank", gap, eff(int'(cfg_hblank)));
          run = 0;
        end
        if (lsync) run++;
        if (!lsync && prev_l) begin
          chk(run == AP, "R1 line length", run, AP);
          if (fsync) lines++; else fill_cnt++;
          gap = 0;
        end
        if (!fsync && prev_f) begin
          chk(lines == AL, "R1 lines per frame", lines, AL);
          chk(gap == eff(int'(cfg_trail)), "R3 trail", gap, eff(int'(cfg_trail)));
        end
        if (!lsync) gap++;
        if (gl_out && !prev_g) begin
          chk(fsync && !prev_f, "R8 genlock out with frame start", int'(fsync), 1);
          glp++; glrun = 0;
        end
        if (gl_out) glrun++;
        if (!gl_out && prev_g) chk(glrun == PL, "R8 genlock out width", glrun, PL);
        prev_f = fsync; prev_l = lsync; prev_g = gl_out;
        if (pix_ready) begin
          logic [DW-1:0] w;
          bit v;
          w = DW'(sent * 37 + 5);
          v = !(underrun && (sent % 5 == 3));
          pix_valid = v;
          pix_data  = w;
          exp_ring[sent % 4] = !v ? '0 : (sel_wide ? w : {w[7:0], 6'b0});
          sent++;
        end else pix_valid = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int f0, g0, df;
    cyc(5);
    @(negedge clk);
    chk(!fsync && !lsync && vid_data == '0 && !gl_out, "R11 in reset", int'(fsync), 0);
    cyc(1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!fsync && vid_data == '0 && !gl_out && !gl_oe, "R11 after reset", int'(fsync), 0);

    // follower idle: filler only, then one frame per edge
    cyc(100);
    chk(frames == 0, "R5 no frame without edge", frames, 0);
    chk(fill_cnt >= 5, "R6 filler lines while idle", fill_cnt, 5);
    pulse(30, 150);
    chk(frames == 1, "R5 edge starts one frame", frames, 1);

    // edges arriving inside a frame: held and merged
    gl_in = 1'b1; cyc(5); gl_in = 1'b0;
    for (int i = 0; i < 200 && frames < 2; i++) cyc(1);
    cyc(8);
    pulse(3, 3);
    pulse(3, 3);
    cyc(200);
    chk(frames == 3, "R7 held edges give one extra frame", frames, 3);
    chk(fill_at_start == 0, "R7 no filler before held frame", fill_at_start, 0);

    // narrow data, underrun slots, porch lengths of zero and other sizes
    sel_wide = 1'b0; underrun = 1'b1;
    cfg_lead = 0; cfg_trail = 4; cfg_hblank = 1;
    cyc(20);
    pulse(10, 150);
    chk(frames == 4, "R9 narrow frame started", frames, 4);

    // long genlock high time: still a single frame
    sel_wide = 1'b1; underrun = 1'b0;
    cfg_lead = 3; cfg_trail = 1; cfg_hblank = 2;
    cyc(20);
    pulse(300, 100);
    chk(frames == 5, "R5 high time has no effect", frames, 5);

    // leader mode
    cfg_hblank = 3; cfg_lead = 2; cfg_trail = 2;
    f0 = frames; g0 = glp;
    mode_master = 1'b1;
    @(negedge clk);
    chk(gl_oe == 1'b1, "R8 pad enable in leader mode", int'(gl_oe), 1);
    cyc(600);
    df = frames - f0;
    chk(df >= 9 && df <= 11, "R8 leader frame rate", df, 10);
    chk(glp - g0 == df, "R8 one genlock pulse per frame", glp - g0, df);
    mode_master = 1'b0;
    cyc(20);
    @(negedge clk);
    chk(!gl_oe && !gl_out, "R8 follower pad released", int'(gl_oe), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule